// File: doc/BRIEF.md
# Per-Block Write-Protect Lock Manager

This block holds a three-state write-protect flag for every erase block of a flash array. The three states are unlocked, locked and lock-tight. A host loads a first and a last block index into two range registers and then issues one of four lock command codes. The block walks the chosen range one block per clock cycle and applies the state rule of the command to each block it visits.

While the walk runs, `busy_o` is high and any new command or range write is dropped. The block signals the end of the walk with a one-cycle `done_o` pulse, which an interrupt register outside the block collects. A status register always holds the state most recently given to a block. A program or erase engine can read the state of any block at any time through a combinational query port.

The lock-tight state is a one-way door. Only a locked block can enter it, and neither unlock nor lock can take a block out of it. A reset is the only way back.

Top module: `wp_lock_mgr`

## Requirements
- R1: A block state is a 3-bit one-hot value: 3'b001 is lock-tight, 3'b010 is locked and 3'b100 is unlocked. `qry_state_o` shows the state of block `qry_blk_i` combinationally. `qry_wp_o` is 1 for any state other than unlocked.
- R2: After reset every block is locked. `wp_status_o` reads 3'b010, both range registers read 0, and `busy_o`, `done_o` and `err_o` are 0.
- R3: These command codes are accepted when `cmd_valid_i` is high while idle:
  - 8'h23 unlocks the blocks from the start register through the end register, both ends included.
  - 8'h2A locks that same range.
  - 8'h2C makes that same range lock-tight.
  - 8'h27 unlocks every block, from 0 through NBLK-1.
- R4: Each accepted command visits one block per clock cycle. `busy_o` rises in the cycle after the command is accepted and stays high for (blocks visited + 1) cycles. `done_o` is high for exactly one cycle, the last busy cycle.
- R5: Unlock and lock leave a lock-tight block unchanged. Lock-tight leaves an unlocked block unchanged.
- R6: A range write stores `blk_addr_i` ANDed with NBLK-1.
  - Writing the start register stores the same masked value in the end register as well.
  - If the start and end registers are written in the same cycle, the end register takes the end value.
- R7: Each block whose state changes writes its new state into `wp_status_o`. A command that changes no block leaves `wp_status_o` as it was.
- R8: If the start register is greater than the end register, a range command visits no block. The command then completes with one busy cycle, in which `done_o` is high.
- R9: While `busy_o` is high, commands and range-register writes are ignored. Any command code other than the four in R3 is ignored and starts no walk.
- R10: If the walk reaches an index at or above NBLK, the walk stops and `err_o` pulses together with `done_o`. Because the range registers are masked, every command completes with `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code |
| start_we_i | input | 1 | Write enable for the start range register |
| end_we_i | input | 1 | Write enable for the end range register |
| blk_addr_i | input | DW (16) | Block index to write into the range register |
| qry_blk_i | input | log2(NBLK) (4) | Block index to query |
| start_blk_o | output | DW (16) | Start range register |
| end_blk_o | output | DW (16) | End range register |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Range-error pulse, given together with done |
| wp_status_o | output | 3 | Most recently written block state |
| qry_state_o | output | 3 | State of the queried block |
| qry_wp_o | output | 1 | Queried block is write-protected |

## Verification
A wrong stored block state shows up on the query port in the cycle right after the walk visits that block. It also shows up in the status register at the `done_o` pulse that closes the command. A wrong walk counter or wrong range bounds show up at the ports as a wrong count of busy cycles before `done_o`, or as blocks outside the range that changed state. The bench therefore scores every command on three things: the status value at done, the error flag at done, and the number of busy cycles. After each command it also sweeps the query port over all blocks and compares them against a reference model.

// File: rtl/lockmgr_pkg.sv
package lockmgr_pkg;

  typedef logic [2:0] blk_st_t;

  localparam blk_st_t ST_TIGHT    = 3'b001;
  localparam blk_st_t ST_LOCKED   = 3'b010;
  localparam blk_st_t ST_UNLOCKED = 3'b100;

  typedef enum logic [1:0] {
    OP_UNLOCK = 2'd0,
    OP_LOCK   = 2'd1,
    OP_TIGHT  = 2'd2
  } lk_op_e;

  localparam logic [7:0] CMD_UNLOCK_RNG = 8'h23;
  localparam logic [7:0] CMD_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] CMD_LOCK_RNG   = 8'h2A;
  localparam logic [7:0] CMD_TIGHT_RNG  = 8'h2C;

  // State rule applied to one visited block.
  function automatic blk_st_t lk_next(lk_op_e op, blk_st_t cur);
    blk_st_t nxt;
    nxt = cur;
    case (op)
      OP_UNLOCK: if (cur != ST_TIGHT)    nxt = ST_UNLOCKED;
      OP_LOCK:   if (cur != ST_TIGHT)    nxt = ST_LOCKED;
      OP_TIGHT:  if (cur != ST_UNLOCKED) nxt = ST_TIGHT;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
  parameter int NBLK = 16,
  parameter int DW   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          start_we_i,
  input  logic          end_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] start_o,
  output logic [DW-1:0] end_o
);

  localparam logic [DW-1:0] MASK = DW'(NBLK - 1);

  logic [DW-1:0] start_q, start_d;
  logic [DW-1:0] end_q, end_d;
  logic [DW-1:0] masked;
  logic          wr_start, wr_end;

  assign masked   = wdata_i & MASK;
  assign wr_start = start_we_i && !busy_i;
  assign wr_end   = end_we_i && !busy_i;

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    if (wr_start) begin
      start_d = masked;
      end_d   = masked;
    end
    if (wr_end) begin
      end_d = masked;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (wr_start) start_q <= start_d;
      if (wr_start || wr_end) end_q <= end_d;
    end
  end

  assign start_o = start_q;
  assign end_o   = end_q;

  // R9: writes during a walk leave both registers untouched
  p_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(start_q) && $stable(end_q)));

  // R6: a start write is mirrored into the end register
  p_start_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_we_i && !end_we_i && !busy_i) |=> (end_q == start_q));

endmodule

// File: rtl/wp_walk_ctrl.sv
module wp_walk_ctrl
  import lockmgr_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int DW   = 16,
  parameter int AW   = $clog2(NBLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_code_i,
  input  logic [DW-1:0] start_i,
  input  logic [DW-1:0] end_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          visit_o,
  output logic [AW-1:0] visit_blk_o,
  output lk_op_e        op_o
);

  localparam logic [DW-1:0] LIMIT = DW'(NBLK);
  localparam logic [DW-1:0] TOP   = DW'(NBLK - 1);

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_WALK = 2'd1,
    W_FIN  = 2'd2
  } walk_st_e;

  walk_st_e      st_q, st_d;
  logic [DW-1:0] cur_q, cur_d;
  logic [DW-1:0] last_q, last_d;
  lk_op_e        op_q, op_d;
  logic          err_q, err_d;

  logic          known;
  logic          all_sel;
  lk_op_e        dec_op;
  logic [DW-1:0] first_idx, last_idx;
  logic          in_range;

  // Command decode
  always_comb begin
    known   = 1'b1;
    all_sel = 1'b0;
    dec_op  = OP_UNLOCK;
    case (cmd_code_i)
      CMD_UNLOCK_RNG: dec_op = OP_UNLOCK;
      CMD_UNLOCK_ALL: begin
        dec_op  = OP_UNLOCK;
        all_sel = 1'b1;
      end
      CMD_LOCK_RNG:   dec_op = OP_LOCK;
      CMD_TIGHT_RNG:  dec_op = OP_TIGHT;
      default:        known = 1'b0;
    endcase
  end

  assign first_idx = all_sel ? '0  : start_i;
  assign last_idx  = all_sel ? TOP : end_i;
  assign in_range  = (cur_q < LIMIT);

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    last_d = last_q;
    op_d   = op_q;
    err_d  = err_q;
    case (st_q)
      W_IDLE: begin
        err_d = 1'b0;
        if (cmd_valid_i && known) begin
          op_d   = dec_op;
          cur_d  = first_idx;
          last_d = last_idx;
          st_d   = (first_idx > last_idx) ? W_FIN : W_WALK;
        end
      end
      W_WALK: begin
        if (!in_range) begin
          err_d = 1'b1;
          st_d  = W_FIN;
        end else if (cur_q == last_q) begin
          st_d = W_FIN;
        end else begin
          cur_d = cur_q + 1'b1;
        end
      end
      W_FIN: begin
        st_d  = W_IDLE;
        err_d = 1'b0;
      end
      default: st_d = W_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      cur_q  <= '0;
      last_q <= '0;
      op_q   <= OP_UNLOCK;
      err_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (st_q != W_FIN) begin
        cur_q  <= cur_d;
        last_q <= last_d;
        op_q   <= op_d;
      end
    end
  end

  assign busy_o      = (st_q != W_IDLE);
  assign done_o      = (st_q == W_FIN);
  assign err_o       = (st_q == W_FIN) && err_q;
  assign visit_o     = (st_q == W_WALK) && in_range;
  assign visit_blk_o = cur_q[AW-1:0];
  assign op_o        = op_q;

  // R4: done lasts a single cycle and is followed by idle
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R4: the walk steps one block per cycle
  p_walk_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (visit_o && cur_q != last_q) |=> (cur_q == $past(cur_q) + 1'b1));

  // R10: error is reported only inside the done cycle
  p_err_in_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R9: a command while busy does not restart the walk
  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_WALK && cur_q != last_q && in_range) |=> (st_q == W_WALK));

endmodule

// File: rtl/wp_state_array.sv
module wp_state_array
  import lockmgr_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int AW   = $clog2(NBLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          visit_i,
  input  logic [AW-1:0] visit_blk_i,
  input  lk_op_e        op_i,
  input  logic [AW-1:0] qry_blk_i,
  output blk_st_t       qry_state_o,
  output logic          chg_o,
  output blk_st_t       new_st_o
);

  blk_st_t blk_q [NBLK];
  blk_st_t sel_st;
  blk_st_t nxt_st;

  assign sel_st   = blk_q[visit_blk_i];
  assign nxt_st   = lk_next(op_i, sel_st);
  assign chg_o    = visit_i && (nxt_st != sel_st);
  assign new_st_o = nxt_st;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic    en;
    blk_st_t blk_d;

    assign en    = chg_o && (visit_blk_i == AW'(i));
    assign blk_d = en ? nxt_st : blk_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        blk_q[i] <= ST_LOCKED;
      end else if (en) begin
        blk_q[i] <= blk_d;
      end
    end

    // R5: lock-tight is never left
    p_tight_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blk_q[i] == ST_TIGHT) |=> (blk_q[i] == ST_TIGHT));

    // R5: an unlocked block never goes straight to lock-tight
    p_tight_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blk_q[i] == ST_UNLOCKED) |=> (blk_q[i] != ST_TIGHT));

    // R1: every stored state stays one-hot
    p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(blk_q[i]) == 1);
  end

  assign qry_state_o = blk_q[qry_blk_i];

endmodule

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr
  import lockmgr_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NBLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_code_i,
  input  logic          start_we_i,
  input  logic          end_we_i,
  input  logic [DW-1:0] blk_addr_i,
  input  logic [AW-1:0] qry_blk_i,
  output logic [DW-1:0] start_blk_o,
  output logic [DW-1:0] end_blk_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [2:0]    wp_status_o,
  output logic [2:0]    qry_state_o,
  output logic          qry_wp_o
);

  logic          busy;
  logic          visit;
  logic [AW-1:0] visit_blk;
  lk_op_e        op;
  logic          chg;
  blk_st_t       new_st;
  blk_st_t       qst;
  blk_st_t       wp_q, wp_d;

  wp_range_regs #(.NBLK(NBLK), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .start_we_i (start_we_i),
    .end_we_i   (end_we_i),
    .wdata_i    (blk_addr_i),
    .start_o    (start_blk_o),
    .end_o      (end_blk_o)
  );

  wp_walk_ctrl #(.NBLK(NBLK), .DW(DW), .AW(AW)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .start_i     (start_blk_o),
    .end_i       (end_blk_o),
    .busy_o      (busy),
    .done_o      (done_o),
    .err_o       (err_o),
    .visit_o     (visit),
    .visit_blk_o (visit_blk),
    .op_o        (op)
  );

  wp_state_array #(.NBLK(NBLK), .AW(AW)) u_arr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .visit_i     (visit),
    .visit_blk_i (visit_blk),
    .op_i        (op),
    .qry_blk_i   (qry_blk_i),
    .qry_state_o (qst),
    .chg_o       (chg),
    .new_st_o    (new_st)
  );

  // Status register: last state written into any block
  assign wp_d = new_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= ST_LOCKED;
    end else if (chg) begin
      wp_q <= wp_d;
    end
  end

  assign busy_o      = busy;
  assign wp_status_o = wp_q;
  assign qry_state_o = qst;
  assign qry_wp_o    = (qst != ST_UNLOCKED);

  // R7: status moves only when a block changes
  p_status_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg |=> $stable(wp_q));

  // R4: block states change only while busy
  p_change_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |-> busy_o);

  // R10: masked ranges never produce a range error
  p_no_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o);

endmodule

// File: tb/tb_wp_lock_mgr.sv
`timescale 1ns/1ps
module tb_wp_lock_mgr;

  localparam int NBLK = 16;
  localparam int DW   = 16;
  localparam int AW   = 4;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [7:0]    cmd_code;
  logic          start_we;
  logic          end_we;
  logic [DW-1:0] blk_addr;
  logic [AW-1:0] qry_blk;
  logic [DW-1:0] start_blk, end_blk;
  logic          busy, done, err;
  logic [2:0]    wp_status, qry_state;
  logic          qry_wp;

  wp_lock_mgr #(.NBLK(NBLK), .DW(DW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_code_i  (cmd_code),
    .start_we_i  (start_we),
    .end_we_i    (end_we),
    .blk_addr_i  (blk_addr),
    .qry_blk_i   (qry_blk),
    .start_blk_o (start_blk),
    .end_blk_o   (end_blk),
    .busy_o      (busy),
    .done_o      (done),
    .err_o       (err),
    .wp_status_o (wp_status),
    .qry_state_o (qry_state),
    .qry_wp_o    (qry_wp)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [2:0] wp;
    logic       err;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t exp_q [$];

  int n_checks = 0;
  int n_errors = 0;
  int busy_cnt = 0;

  // Reference model
  logic [2:0] mdl [NBLK];
  logic [2:0] m_wp;
  int         m_start, m_end;

  localparam logic [2:0] S_T = 3'b001;
  localparam logic [2:0] S_L = 3'b010;
  localparam logic [2:0] S_U = 3'b100;

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [2:0] rule(input logic [7:0] code, input logic [2:0] cur);
    logic [2:0] n;
    n = cur;
    case (code)
      8'h23, 8'h27: if (cur != S_T) n = S_U;
      8'h2A:        if (cur != S_T) n = S_L;
      8'h2C:        if (cur != S_U) n = S_T;
      default:      n = cur;
    endcase
    return n;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(wp_status == e.wp, {e.tag, " R7 status"}, int'(wp_status), int'(e.wp));
          check(err == e.err, {e.tag, " R10 err"}, int'(err), int'(e.err));
          check(busy_cnt == e.cyc, {e.tag, " R4 busy cycles"}, busy_cnt, e.cyc);
        end
        busy_cnt = 0;
      end
    end
  end

  task automatic wr_start(input int v);
    @(negedge clk);
    start_we = 1'b1;
    blk_addr = DW'(v);
    @(negedge clk);
    start_we = 1'b0;
    m_start = v & (NBLK - 1);
    m_end   = m_start;
  endtask

  task automatic wr_end(input int v);
    @(negedge clk);
    end_we   = 1'b1;
    blk_addr = DW'(v);
    @(negedge clk);
    end_we = 1'b0;
    m_end = v & (NBLK - 1);
  endtask

  task automatic predict(input logic [7:0] code, input string tag);
    int   lo, hi, visits;
    exp_t e;
    if (code == 8'h27) begin
      lo = 0;
      hi = NBLK - 1;
    end else begin
      lo = m_start;
      hi = m_end;
    end
    visits = (lo <= hi) ? (hi - lo + 1) : 0;
    for (int b = lo; b <= hi; b++) begin
      logic [2:0] n;
      n = rule(code, mdl[b]);
      if (n != mdl[b]) begin
        mdl[b] = n;
        m_wp   = n;
      end
    end
    e.wp  = m_wp;
    e.err = 1'b0;
    e.cyc = visits + 1;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] code, input string tag);
    predict(code, tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic sweep(input string tag);
    for (int b = 0; b < NBLK; b++) begin
      qry_blk = AW'(b);
      #1;
      check(qry_state == mdl[b], {tag, " R1 state"}, int'(qry_state), int'(mdl[b]));
      check(qry_wp == (mdl[b] != S_U), {tag, " R1 wp"}, int'(qry_wp), int'(mdl[b] != S_U));
    end
  endtask

  bit finished = 0;

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_code = 8'h00;
    start_we = 1'b0;
    end_we = 1'b0;
    blk_addr = '0;
    qry_blk = '0;
    for (int b = 0; b < NBLK; b++) mdl[b] = S_L;
    m_wp = S_L;
    m_start = 0;
    m_end = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check(wp_status == 3'b010, "R2 status", int'(wp_status), 2);
    check(start_blk == 0 && end_blk == 0, "R2 range", int'(start_blk), 0);
    check(!busy && !done && !err, "R2 idle", int'({busy, done, err}), 0);
    sweep("R2");

    // R6 masking and mirroring
    wr_start(16'h0025);
    check(start_blk == 16'd5, "R6 start mask", int'(start_blk), 5);
    check(end_blk == 16'd5, "R6 end copy", int'(end_blk), 5);
    wr_end(16'h003A);
    check(end_blk == 16'd10, "R6 end mask", int'(end_blk), 10);
    @(negedge clk);
    start_we = 1'b1;
    end_we   = 1'b1;
    blk_addr = 16'd12;
    @(negedge clk);
    start_we = 1'b0;
    end_we   = 1'b0;
    check(start_blk == 16'd12 && end_blk == 16'd12, "R6 both writes", int'(end_blk), 12);
    wr_start(5);
    wr_end(10);

    // R3 range unlock
    run_cmd(8'h23, "R3 unlock 5..10");
    sweep("R3 unlock");

    // R5 lock-tight skips unlocked blocks
    wr_start(7);
    wr_end(8);
    run_cmd(8'h2C, "R5 tight on unlocked");
    sweep("R5 tight on unlocked");

    // R3 lock-tight on locked blocks
    wr_start(0);
    wr_end(2);
    run_cmd(8'h2C, "R3 tight 0..2");
    sweep("R3 tight");

    // R3 unlock all, R5 tight blocks kept
    run_cmd(8'h27, "R3 unlock all");
    sweep("R5 unlock all");

    // R3 lock full range
    wr_start(0);
    wr_end(15);
    run_cmd(8'h2A, "R3 lock 0..15");
    sweep("R3 lock");

    // R5 and R7: unlock over tight-only range changes nothing
    wr_start(0);
    wr_end(2);
    run_cmd(8'h23, "R5 unlock tight");
    sweep("R5 unlock tight");

    // R8 inverted range
    wr_start(9);
    wr_end(4);
    run_cmd(8'h2A, "R8 empty range");
    sweep("R8");

    // R9 commands and writes during busy ignored
    wr_start(3);
    wr_end(12);
    predict(8'h23, "R9 busy ignore");
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = 8'h23;
    @(negedge clk);
    cmd_code  = 8'h2A;
    start_we  = 1'b1;
    blk_addr  = 16'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    start_we  = 1'b0;
    wait_idle();
    check(start_blk == 16'd3 && end_blk == 16'd12, "R9 range held", int'(start_blk), 3);
    sweep("R9");

    // R9 non-lock code starts no walk
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = 8'h94;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!busy && !done, "R9 unknown code", int'(busy), 0);
    repeat (2) @(negedge clk);

    check(exp_q.size() == 0, "R4 pending completions", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule